// File: doc/BRIEF.md
# Mid-Capture Speed Switch Sequencer for a Full-Speed Bus Analyzer

A passive analyzer watching a Full-Speed link between a host and a hub may also see Low-Speed traffic. The host sends that traffic to a Low-Speed device through the hub. It announces each such packet with a one-byte preamble token, and then the signalling drops to Low-Speed. This block sits next to the transceiver link controller and watches the receive stream. When the first byte of a packet is the preamble identifier, the block does three things: it cuts the receive short, it programs the transceiver for Low-Speed reception, and it later restores Full-Speed once a Low-Speed packet has ended.

The block owns the controller's register-write port. It merges its own speed writes with register writes requested from outside. Its own writes are never acknowledged outward. Every received byte is passed on, one cycle later, as a capture stream. Each byte carries a flag that tells whether the transceiver was in Low-Speed when the packet began.

The receive stream has no ready signal, because a bus being observed cannot be stalled. For the same reason the capture stream has no back-pressure: the consumer must accept a byte in every cycle in which `cap_valid` is high. The external register write uses a request/acknowledge handshake. `ext_wr_req` stays high, with its address and data stable, until `ext_wr_ack` pulses.

Top module: `spdseq_top`

## Requirements
- R1: A packet counts as a preamble only when it meets all of these: its first byte (`rx_valid` and `rx_first` high) equals 8'h3C, the sequencer is in the Full-Speed resting state, and no speed switch is pending. The value 8'h3C in any later byte, or while Low-Speed is active, has no effect.
- R2: `stop_req` goes high on the cycle after a preamble byte. It stays high until the cycle after `rx_eop` or the cycle after `rx_active` falls, whichever comes first.
- R3: After a preamble, once `rx_active` is low, the block requests a controller write with command 8'h84 and data 8'h6B. This value is the Low-Speed setting (8'h4B) with the transceiver reset bit (bit 5) also set.
- R4: `ls_mode` goes high on the cycle after the Low-Speed write is acknowledged. The eop of the preamble packet itself does not trigger the return to Full-Speed. The return is armed by the first packet that starts after the acknowledge: at its `rx_eop`, a write with command 8'h84 and data 8'h49 is requested. `ls_mode` falls on the cycle after that write is acknowledged.
- R5: Writes issued by the block itself never raise `ext_wr_ack`. An external write is forwarded with command 8'h80 OR `ext_wr_addr` and data `ext_wr_data`. Its `ctl_wr_ack` is returned as a one-cycle `ext_wr_ack`.
- R6: A pending internal speed write is started ahead of a pending external write. While an internal write is pending or in flight, `ctl_rd_req` is held low.
- R7: `ctl_wr_req` is low whenever `rx_active` is high. A write that is not yet acknowledged when a receive starts is raised again, unchanged, once `rx_active` falls.
- R8: If no eop of a packet that started after the Low-Speed acknowledge arrives within WDOG_CYCLES cycles of that acknowledge, the Full-Speed write is requested anyway.
- R9: The capture outputs repeat `rx_valid`, `rx_data`, `rx_first` and `rx_eop` one cycle later. `cap_ls` is taken from the speed state at the packet's first byte and held for every byte of that packet, through its eop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Controller is receiving (bus turned toward the analyzer) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Marks the first byte of a packet |
| rx_eop | input | 1 | End-of-packet strobe |
| stop_req | output | 1 | Asks the controller to cut the current receive short |
| cap_valid | output | 1 | Capture byte strobe |
| cap_data | output | 8 | Capture byte |
| cap_first | output | 1 | Capture first-byte marker |
| cap_eop | output | 1 | Capture end-of-packet strobe |
| cap_ls | output | 1 | Packet was received at Low-Speed |
| ext_wr_req | input | 1 | External register write request (level) |
| ext_wr_addr | input | 6 | External register address |
| ext_wr_data | input | 8 | External register data |
| ext_wr_ack | output | 1 | External write done (one cycle) |
| ext_rd_req | input | 1 | External register read request |
| ctl_rd_req | output | 1 | Read request forwarded to the controller |
| ctl_wr_req | output | 1 | Write request to the controller (level) |
| ctl_wr_cmd | output | 8 | Write command byte |
| ctl_wr_data | output | 8 | Write data byte |
| ctl_wr_ack | input | 1 | Controller write acknowledge |
| ls_mode | output | 1 | Low-Speed setting is active |

## Verification
The bench sends the value 8'h3C in a later byte and as the first byte while Low-Speed is active. A detector that does not check the first-byte marker or the speed state would stop a good packet or program the transceiver again. It also lets the eop of the preamble packet pass before any acknowledge. A sequencer that arms too early would restore Full-Speed before the Low-Speed packet arrives. It starts a receive while the Low-Speed write is still unacknowledged. It then checks that the request drops during the receive and comes back afterwards; a design that lost it would stay at Full-Speed. It races an external write and a read against the internal write, checks that the internal acknowledge never leaks outward, and lets the watchdog expire to confirm that the block cannot stay stuck at Low-Speed.

// File: rtl/spdseq_pkg.sv
package spdseq_pkg;
  localparam logic [7:0] PRE_PID      = 8'h3C;
  localparam logic [7:0] FCTL_WR_CMD  = 8'h84;
  localparam logic [7:0] XCVR_RST_BIT = 8'h20;
  localparam logic [7:0] FCTL_LS      = 8'h4B | XCVR_RST_BIT;
  localparam logic [7:0] FCTL_FS      = 8'h49;
  localparam logic [7:0] REGW_BASE    = 8'h80;

  typedef enum logic [1:0] {
    SP_FS     = 2'd0,
    SP_LS_REQ = 2'd1,
    SP_LS_ARM = 2'd2,
    SP_FS_REQ = 2'd3
  } spd_state_e;
endpackage

// File: rtl/spdseq_pre_det.sv
module spdseq_pre_det
  import spdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_rest,
  input  logic       rx_active,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic [7:0] rx_data,
  input  logic       rx_eop,
  output logic       pre_hit,
  output logic       stop_req
);
  assign pre_hit = fs_rest && rx_valid && rx_first && (rx_data == PRE_PID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_req <= 1'b0;
    end else if (rx_eop || !rx_active) begin
      stop_req <= 1'b0;
    end else if (pre_hit) begin
      stop_req <= 1'b1;
    end
  end
endmodule

// File: rtl/spdseq_fsm.sv
module spdseq_fsm
  import spdseq_pkg::*;
#(
  parameter int WDOG_CYCLES = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pre_hit,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic       rx_eop,
  input  logic       int_done,
  output logic       fs_rest,
  output logic       int_req,
  output logic [7:0] int_data,
  output logic       ls_mode
);
  localparam int WDW = $clog2(WDOG_CYCLES + 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WDOG_CYCLES - 1);

  spd_state_e st;
  logic [WDW-1:0] wd_cnt;
  logic seen_start;
  logic started_now;

  assign started_now = rx_valid && rx_first;
  assign fs_rest  = (st == SP_FS);
  assign int_req  = (st == SP_LS_REQ) || (st == SP_FS_REQ);
  assign int_data = (st == SP_LS_REQ) ? FCTL_LS : FCTL_FS;
  assign ls_mode  = (st == SP_LS_ARM) || (st == SP_FS_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SP_FS;
      wd_cnt     <= '0;
      seen_start <= 1'b0;
    end else begin
      case (st)
        SP_FS: begin
          if (pre_hit) st <= SP_LS_REQ;
        end
        SP_LS_REQ: begin
          if (int_done) begin
            st         <= SP_LS_ARM;
            wd_cnt     <= '0;
            seen_start <= 1'b0;
          end
        end
        SP_LS_ARM: begin
          wd_cnt <= wd_cnt + 1'b1;
          if (started_now) seen_start <= 1'b1;
          if ((rx_eop && (seen_start || started_now)) || (wd_cnt == WD_LAST))
            st <= SP_FS_REQ;
        end
        SP_FS_REQ: begin
          if (int_done) st <= SP_FS;
        end
        default: st <= SP_FS;
      endcase
    end
  end
endmodule

// File: rtl/spdseq_reg_arb.sv
module spdseq_reg_arb
  import spdseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              int_req,
  input  logic [7:0]        int_data,
  output logic              int_done,
  input  logic              ext_wr_req,
  input  logic [ADDR_W-1:0] ext_wr_addr,
  input  logic [7:0]        ext_wr_data,
  output logic              ext_wr_ack,
  input  logic              ext_rd_req,
  output logic              ctl_rd_req,
  output logic              ctl_wr_req,
  output logic [7:0]        ctl_wr_cmd,
  output logic [7:0]        ctl_wr_data,
  input  logic              ctl_wr_ack,
  output logic              busy_int
);
  logic busy, is_int, start, done;

  assign start      = !busy && !rx_active && (int_req || ext_wr_req);
  assign ctl_wr_req = busy && !rx_active;
  assign done       = ctl_wr_req && ctl_wr_ack;
  assign int_done   = done && is_int;
  assign ext_wr_ack = done && !is_int;
  assign busy_int   = busy && is_int;
  assign ctl_rd_req = ext_rd_req && !busy && !int_req && !rx_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      is_int      <= 1'b0;
      ctl_wr_cmd  <= '0;
      ctl_wr_data <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      is_int <= int_req;
      if (int_req) begin
        ctl_wr_cmd  <= FCTL_WR_CMD;
        ctl_wr_data <= int_data;
      end else begin
        ctl_wr_cmd  <= REGW_BASE | 8'(ext_wr_addr);
        ctl_wr_data <= ext_wr_data;
      end
    end else if (done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spdseq_cap_tag.sv
module spdseq_cap_tag #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ls_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_first,
  input  logic          rx_eop,
  output logic          cap_valid,
  output logic [DW-1:0] cap_data,
  output logic          cap_first,
  output logic          cap_eop,
  output logic          cap_ls
);
  logic pkt_ls, flag_now, at_start;

  assign at_start = rx_valid && rx_first;
  assign flag_now = at_start ? ls_mode : pkt_ls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_ls    <= 1'b0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
      cap_first <= 1'b0;
      cap_eop   <= 1'b0;
      cap_ls    <= 1'b0;
    end else begin
      if (at_start) pkt_ls <= ls_mode;
      cap_valid <= rx_valid;
      cap_data  <= rx_data;
      cap_first <= at_start;
      cap_eop   <= rx_eop;
      cap_ls    <= flag_now;
    end
  end
endmodule

// File: rtl/spdseq_top.sv
module spdseq_top
  import spdseq_pkg::*;
#(
  parameter int WDOG_CYCLES = 60000,
  parameter int ADDR_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_first,
  input  logic              rx_eop,
  output logic              stop_req,
  output logic              cap_valid,
  output logic [7:0]        cap_data,
  output logic              cap_first,
  output logic              cap_eop,
  output logic              cap_ls,
  input  logic              ext_wr_req,
  input  logic [ADDR_W-1:0] ext_wr_addr,
  input  logic [7:0]        ext_wr_data,
  output logic              ext_wr_ack,
  input  logic              ext_rd_req,
  output logic              ctl_rd_req,
  output logic              ctl_wr_req,
  output logic [7:0]        ctl_wr_cmd,
  output logic [7:0]        ctl_wr_data,
  input  logic              ctl_wr_ack,
  output logic              ls_mode
);
  logic fs_rest, pre_hit, int_req, int_done, busy_int;
  logic [7:0] int_data;

  spdseq_pre_det u_det (
    .clk(clk), .rst_n(rst_n), .fs_rest(fs_rest), .rx_active(rx_active),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
    .rx_eop(rx_eop), .pre_hit(pre_hit), .stop_req(stop_req)
  );

  spdseq_fsm #(.WDOG_CYCLES(WDOG_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pre_hit(pre_hit), .rx_valid(rx_valid),
    .rx_first(rx_first), .rx_eop(rx_eop), .int_done(int_done),
    .fs_rest(fs_rest), .int_req(int_req), .int_data(int_data),
    .ls_mode(ls_mode)
  );

  spdseq_reg_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active),
    .int_req(int_req), .int_data(int_data), .int_done(int_done),
    .ext_wr_req(ext_wr_req), .ext_wr_addr(ext_wr_addr),
    .ext_wr_data(ext_wr_data), .ext_wr_ack(ext_wr_ack),
    .ext_rd_req(ext_rd_req), .ctl_rd_req(ctl_rd_req),
    .ctl_wr_req(ctl_wr_req), .ctl_wr_cmd(ctl_wr_cmd),
    .ctl_wr_data(ctl_wr_data), .ctl_wr_ack(ctl_wr_ack),
    .busy_int(busy_int)
  );

  spdseq_cap_tag #(.DW(8)) u_tag (
    .clk(clk), .rst_n(rst_n), .ls_mode(ls_mode), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .rx_eop(rx_eop),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_first(cap_first),
    .cap_eop(cap_eop), .cap_ls(cap_ls)
  );
endmodule

// File: rtl/spdseq_chk.sv
module spdseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_active,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_first,
  input logic       rx_eop,
  input logic       stop_req,
  input logic       fs_rest,
  input logic       cap_valid,
  input logic       cap_first,
  input logic       cap_eop,
  input logic       cap_ls,
  input logic       ext_wr_req,
  input logic       ext_wr_ack,
  input logic       ctl_rd_req,
  input logic       ctl_wr_req,
  input logic [7:0] ctl_wr_data,
  input logic       busy_int,
  input logic       int_req
);
  a_r2_stop_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rest && rx_active && rx_valid && rx_first && rx_data == 8'h3C && !rx_eop) |=> stop_req);

  a_r7_quiet_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !ctl_wr_req);

  a_r5_ack_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_ack |-> (ext_wr_req && !busy_int));

  a_r3_int_values: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_req && busy_int) |-> (ctl_wr_data == 8'h6B || ctl_wr_data == 8'h49));

  a_r6_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_req |-> (!ctl_wr_req && !int_req));

  a_r9_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_first && $past(cap_valid) && !$past(cap_eop)) |-> $stable(cap_ls));
endmodule

bind spdseq_top spdseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_first(rx_first), .rx_eop(rx_eop),
  .stop_req(stop_req), .fs_rest(fs_rest), .cap_valid(cap_valid),
  .cap_first(cap_first), .cap_eop(cap_eop), .cap_ls(cap_ls),
  .ext_wr_req(ext_wr_req), .ext_wr_ack(ext_wr_ack), .ctl_rd_req(ctl_rd_req),
  .ctl_wr_req(ctl_wr_req), .ctl_wr_data(ctl_wr_data), .busy_int(busy_int),
  .int_req(int_req)
);

// File: tb/spdseq_top_tb.sv
module spdseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 300;

  logic clk = 0, rst_n = 0;
  logic rx_active = 0, rx_valid = 0, rx_first = 0, rx_eop = 0;
  logic [7:0] rx_data = 0;
  logic stop_req, cap_valid, cap_first, cap_eop, cap_ls;
  logic [7:0] cap_data;
  logic ext_wr_req = 0, ext_rd_req = 0, ctl_wr_ack = 0;
  logic [5:0] ext_wr_addr = 0;
  logic [7:0] ext_wr_data = 0;
  logic ext_wr_ack, ctl_rd_req, ctl_wr_req, ls_mode;
  logic [7:0] ctl_wr_cmd, ctl_wr_data;
  int n_run = 0, n_fail = 0;
  int ext_acks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (ext_wr_ack) ext_acks++;

  spdseq_top #(.WDOG_CYCLES(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .rx_eop(rx_eop),
    .stop_req(stop_req), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_first(cap_first), .cap_eop(cap_eop), .cap_ls(cap_ls),
    .ext_wr_req(ext_wr_req), .ext_wr_addr(ext_wr_addr),
    .ext_wr_data(ext_wr_data), .ext_wr_ack(ext_wr_ack),
    .ext_rd_req(ext_rd_req), .ctl_rd_req(ctl_rd_req),
    .ctl_wr_req(ctl_wr_req), .ctl_wr_cmd(ctl_wr_cmd),
    .ctl_wr_data(ctl_wr_data), .ctl_wr_ack(ctl_wr_ack), .ls_mode(ls_mode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // Drives one packet; all inputs change at negedge. Checks capture on each byte.
  task automatic send_pkt(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic exp_ls, input string req);
    logic [7:0] b [3];
    b[0] = b0; b[1] = b1; b[2] = b2;
    rx_active = 1; tick();
    for (int i = 0; i < 3; i++) begin
      rx_valid = 1; rx_data = b[i]; rx_first = (i == 0); rx_eop = (i == 2);
      tick();
      chk({req, " cap_data"}, {8'h0, cap_data}, {8'h0, b[i]});
      chk({req, " cap_ls"}, {15'h0, cap_ls}, {15'h0, exp_ls});
    end
    rx_valid = 0; rx_first = 0; rx_eop = 0; tick();
    rx_active = 0; tick();
  endtask

  task automatic wait_req(input int max);
    for (int i = 0; i < max && !ctl_wr_req; i++) tick();
  endtask

  task automatic ack_once();
    ctl_wr_ack = 1; tick(); ctl_wr_ack = 0;
  endtask

  task automatic t_reset();
    chk("R2 reset stop", {15'h0, stop_req}, 16'h0);
    chk("R4 reset ls", {15'h0, ls_mode}, 16'h0);
    chk("R7 reset wreq", {15'h0, ctl_wr_req}, 16'h0);
    chk("R9 reset cap", {15'h0, cap_valid}, 16'h0);
  endtask

  task automatic t_plain();
    send_pkt(8'h69, 8'h3C, 8'h3C, 1'b0, "R9 fs pkt");
    chk("R1 late 3C no stop", {15'h0, stop_req}, 16'h0);
    repeat (4) tick();
    chk("R1 late 3C no write", {15'h0, ctl_wr_req}, 16'h0);
    chk("R1 late 3C no ls", {15'h0, ls_mode}, 16'h0);
  endtask

  task automatic t_pre_cycle();
    rx_active = 1; tick();
    rx_valid = 1; rx_data = 8'h3C; rx_first = 1; tick();
    rx_valid = 0; rx_first = 0;
    chk("R2 stop raised", {15'h0, stop_req}, 16'h1);
    chk("R7 no req in rx", {15'h0, ctl_wr_req}, 16'h0);
    tick();
    chk("R2 stop held", {15'h0, stop_req}, 16'h1);
    rx_eop = 1; tick(); rx_eop = 0;
    chk("R2 stop cleared", {15'h0, stop_req}, 16'h0);
    rx_active = 0;
    wait_req(5);
    chk("R3 ls req", {15'h0, ctl_wr_req}, 16'h1);
    chk("R3 ls cmd", {8'h0, ctl_wr_cmd}, 16'h0084);
    chk("R3 ls data", {8'h0, ctl_wr_data}, 16'h006B);
    // receive starts before ack: request must withdraw, then return
    rx_active = 1; tick();
    chk("R7 withdrawn", {15'h0, ctl_wr_req}, 16'h0);
    tick(); rx_active = 0; tick();
    chk("R7 reissued", {15'h0, ctl_wr_req}, 16'h1);
    chk("R7 reissued data", {8'h0, ctl_wr_data}, 16'h006B);
    chk("R4 not yet ls", {15'h0, ls_mode}, 16'h0);
    ack_once();
    chk("R4 ls after ack", {15'h0, ls_mode}, 16'h1);
    chk("R5 no ext ack", ext_acks[15:0], 16'h0);
    repeat (3) tick();
    chk("R4 no early fs", {15'h0, ctl_wr_req}, 16'h0);
    send_pkt(8'h3C, 8'h11, 8'h22, 1'b1, "R9 ls pkt");
    chk("R1 3C in ls no stop", {15'h0, stop_req}, 16'h0);
    wait_req(5);
    chk("R4 fs req", {15'h0, ctl_wr_req}, 16'h1);
    chk("R4 fs data", {8'h0, ctl_wr_data}, 16'h0049);
    chk("R4 ls kept until ack", {15'h0, ls_mode}, 16'h1);
    ack_once();
    chk("R4 fs after ack", {15'h0, ls_mode}, 16'h0);
    chk("R5 still no ext ack", ext_acks[15:0], 16'h0);
    send_pkt(8'hA5, 8'h01, 8'h02, 1'b0, "R9 fs again");
  endtask

  task automatic t_priority();
    rx_active = 1; tick();
    rx_valid = 1; rx_data = 8'h3C; rx_first = 1; tick();
    rx_valid = 0; rx_first = 0;
    ext_wr_req = 1; ext_wr_addr = 6'h0A; ext_wr_data = 8'h5A; ext_rd_req = 1;
    rx_eop = 1; tick(); rx_eop = 0; rx_active = 0;
    wait_req(5);
    chk("R6 int first data", {8'h0, ctl_wr_data}, 16'h006B);
    chk("R6 read held", {15'h0, ctl_rd_req}, 16'h0);
    ack_once();
    chk("R5 int ack hidden", ext_acks[15:0], 16'h0);
    wait_req(5);
    chk("R5 ext cmd", {8'h0, ctl_wr_cmd}, 16'h008A);
    chk("R5 ext data", {8'h0, ctl_wr_data}, 16'h005A);
    ack_once();
    chk("R5 ext acked", ext_acks[15:0], 16'h1);
    ext_wr_req = 0; tick();
    chk("R6 read passes", {15'h0, ctl_rd_req}, 16'h1);
    ext_rd_req = 0;
  endtask

  task automatic t_watchdog();
    // now armed in Low-Speed; no packet arrives
    repeat (WD - 20) tick();
    chk("R8 not before window", {15'h0, ctl_wr_req}, 16'h0);
    wait_req(40);
    chk("R8 forced fs req", {15'h0, ctl_wr_req}, 16'h1);
    chk("R8 forced fs data", {8'h0, ctl_wr_data}, 16'h0049);
    ack_once();
    chk("R8 back to fs", {15'h0, ls_mode}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_plain();
    t_pre_cycle();
    t_priority();
    t_watchdog();
    repeat (3) tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule